// File: doc/BRIEF.md
# Serial Clock-and-RAM Slave on a Bit-Toggled Control Byte

This block is a real-time-clock and battery-style RAM slave that a host reaches by rewriting a control byte. Three bits of that byte matter to the slave: an enable (bit 0), a serial clock (bit 1) and a serial data bit (bit 2). While enable is set, every host write whose clock bit goes from 1 to 0, compared with the byte held from the previous write, counts as one falling edge. The first eight edges shift in a command byte, MSB first. The next eight edges either shift in a value byte or, for read commands, put a return bit into bit 2 of the stored control byte, where the host reads it back.

The command byte selects one of four operations. It can read or write one of 32 RAM bytes, read a status byte or an auxiliary byte, clear two status flags, or read packed-BCD time and date fields. The time fields come from internal counters that advance on a once-per-second tick input. A status clear also raises a one-cycle acknowledge, which the surrounding chip uses to drop its matching interrupt flag.

The transfer sequencer has four states. IDLE waits for a write with enable set, which moves it into CMD (phase 0). CMD takes eight falling edges and then moves to DATA. DATA takes eight falling edges and then moves to DONE, which is where writes commit. DONE ignores further clocks. A write with enable clear moves any state back to IDLE.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the control byte reads 0x00, the acknowledge output is low, all 32 RAM bytes are 0x00, the status byte is 0x90 and the time is 00:00:00 on day 1, month 1, year 00.
- R2: A write with bit 0 clear returns the sequencer to IDLE and discards any partly shifted command and value. Falling edges written with bit 0 clear have no effect.
- R3: Only a host write whose bit 1 is 0, while the previously stored bit 1 was 1, advances the transfer. Rising edges, and repeated writes with the clock low, do not.
- R4: Commands 0x80 to 0x9F store the eight shifted-in value bits (MSB first) into RAM byte (command - 0x80) on the 16th falling edge.
- R5: Commands 0x00 to 0x1F read RAM byte [command]. On the falling edge of data phase p (0 to 7), bit 2 of the stored control byte becomes bit (7 - p) of that byte.
- R6: Command 0x30 returns the status byte and command 0x31 returns 0x00, both bit-serially as in R5.
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day of month, month (from 1) and two-digit year, each as packed BCD with the tens digit in the upper nibble. The other codes in 0x20 to 0x2F return 0x00.
- R8: Command 0xB1 with value bit 2 set clears status bits 4 and 3 and pulses `irq_ack` high for exactly one cycle. If value bit 2 is clear, neither happens.
- R9: After the 16th falling edge, further falling edges change neither RAM nor status until enable is dropped.
- R10: Each `sec_tick` cycle advances seconds. Seconds and minutes wrap at 60 and hours at 24, and the day, month and year advance on a fixed month-length table with no leap years.
- R11: On every write that does not drive a return bit, bit 2 of the stored control byte is the value the host wrote. The other seven bits are always stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Host writes the control byte this cycle |
| ctl_wdata | input | 8 | Byte written: bit 0 enable, bit 1 serial clock, bit 2 serial data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| ctl_rdata | output | 8 | Stored control byte, with the return bit in bit 2 |
| irq_ack | output | 1 | One-cycle pulse when a status clear commits |

## Verification
Transfers use all four command classes with random addresses and values. Each result is compared against a bench model of the RAM, the status byte and the elapsed seconds, which separates wrong address decoding from wrong bit ordering. Directed transfers interleave redundant writes with the clock held low, and send falling edges while enable is low, to show that only genuine falling edges count. Aborted and over-long transfers show whether commits depend on exactly 16 edges. Long tick bursts cross the minute, hour and day boundaries, so a wrong BCD split or a wrong carry can be told apart.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } xfer_state_t;

    localparam int          CTL_EN        = 0;
    localparam int          CTL_CLK       = 1;
    localparam int          CTL_DAT       = 2;
    localparam logic [7:0]  STATUS_RESET  = 8'h90;
    localparam logic [7:0]  STATUS_CLEAR  = 8'h18;
    localparam logic [7:0]  CMD_STAT_RD   = 8'h30;
    localparam logic [7:0]  CMD_AUX_RD    = 8'h31;
    localparam logic [7:0]  CMD_STAT_WR   = 8'hB1;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] month_len(input logic [6:0] m);
        logic [6:0] d;
        case (m)
            7'd4, 7'd6, 7'd9, 7'd11: d = 7'd30;
            7'd2:                    d = 7'd28;
            default:                 d = 7'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int YEAR_SPAN = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic [6:0] sec,
    output logic [6:0] min,
    output logic [6:0] hour,
    output logic [6:0] mday,
    output logic [6:0] mon,
    output logic [6:0] yr
);
    localparam logic [6:0] YR_LAST = 7'(YEAR_SPAN - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec  <= '0;
            min  <= '0;
            hour <= '0;
            mday <= 7'd1;
            mon  <= 7'd1;
            yr   <= '0;
        end else if (tick) begin
            if (sec != 7'd59) begin
                sec <= sec + 7'd1;
            end else begin
                sec <= '0;
                if (min != 7'd59) begin
                    min <= min + 7'd1;
                end else begin
                    min <= '0;
                    if (hour != 7'd23) begin
                        hour <= hour + 7'd1;
                    end else begin
                        hour <= '0;
                        if (mday != month_len(mon)) begin
                            mday <= mday + 7'd1;
                        end else begin
                            mday <= 7'd1;
                            if (mon != 7'd12) begin
                                mon <= mon + 7'd1;
                            end else begin
                                mon <= 7'd1;
                                yr  <= (yr == YR_LAST) ? '0 : yr + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // R10
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec == 7'd59) |=> (sec == 7'd0));

    // R10
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hour < 7'd24) && (min < 7'd60));

    // R10
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sec));

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_pkg::*;
#(
    parameter int RAM_DEPTH = 32,
    parameter int YEAR_SPAN = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       sec_tick,
    output logic [7:0] ctl_rdata,
    output logic       irq_ack
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);

    xfer_state_t st_q, st_d, eff_st;
    logic [2:0]  cnt_q, cnt_d, eff_cnt;
    logic [7:0]  cmd_q, cmd_d, val_q, val_d;
    logic [7:0]  ctl_q, ctl_d;
    logic [7:0]  stat_q;
    logic        ack_q;

    logic        en_w, clk_w, dat_w, fall;
    logic        commit, ram_we, stat_clr;
    logic [7:0]  final_val;
    logic [7:0]  ret_byte;
    logic        is_read, ret_bit, drive;
    logic [7:0]  ram_rdata;
    logic [6:0]  t_sec, t_min, t_hour, t_mday, t_mon, t_yr;

    assign en_w  = ctl_wdata[CTL_EN];
    assign clk_w = ctl_wdata[CTL_CLK];
    assign dat_w = ctl_wdata[CTL_DAT];
    assign fall  = ctl_we && en_w && ctl_q[CTL_CLK] && !clk_w;

    // IDLE is entered only by a write with enable clear; any write with
    // enable set acts on phase 0 of CMD straight away.
    assign eff_st  = (st_q == ST_IDLE) ? ST_CMD : st_q;
    assign eff_cnt = (st_q == ST_IDLE) ? 3'd0 : cnt_q;

    assign commit    = fall && (eff_st == ST_DATA) && (eff_cnt == 3'd7);
    assign final_val = {val_q[6:0], dat_w};
    assign ram_we    = commit && (cmd_q[7:5] == 3'b100);
    assign stat_clr  = commit && (cmd_q == CMD_STAT_WR) && final_val[2];

    // next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        cmd_d = cmd_q;
        val_d = val_q;
        if (ctl_we) begin
            if (!en_w) begin
                st_d  = ST_IDLE;
                cnt_d = '0;
                cmd_d = '0;
                val_d = '0;
            end else begin
                st_d  = eff_st;
                cnt_d = eff_cnt;
                if (fall) begin
                    unique case (eff_st)
                        ST_CMD: begin
                            cmd_d = {cmd_q[6:0], dat_w};
                            if (eff_cnt == 3'd7) begin
                                st_d  = ST_DATA;
                                cnt_d = '0;
                            end else begin
                                cnt_d = eff_cnt + 3'd1;
                            end
                        end
                        ST_DATA: begin
                            val_d = final_val;
                            if (eff_cnt == 3'd7) begin
                                st_d  = ST_DONE;
                                cnt_d = '0;
                            end else begin
                                cnt_d = eff_cnt + 3'd1;
                            end
                        end
                        ST_IDLE, ST_DONE: begin
                        end
                    endcase
                end
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            cmd_q  <= '0;
            val_q  <= '0;
            ctl_q  <= '0;
            stat_q <= STATUS_RESET;
            ack_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            cmd_q <= cmd_d;
            val_q <= val_d;
            ack_q <= stat_clr;
            if (ctl_we) begin
                ctl_q <= ctl_d;
            end
            if (stat_clr) begin
                stat_q <= stat_q & ~STATUS_CLEAR;
            end
        end
    end

    // output process: return byte selection and data-bit override
    always_comb begin
        ret_byte = '0;
        is_read  = 1'b0;
        if (cmd_q[7:5] == 3'b000) begin
            is_read  = 1'b1;
            ret_byte = ram_rdata;
        end else if (cmd_q[7:4] == 4'h2) begin
            is_read = 1'b1;
            case (cmd_q[3:0])
                4'h0:    ret_byte = to_bcd(t_sec);
                4'h1:    ret_byte = to_bcd(t_min);
                4'h2:    ret_byte = to_bcd(t_hour);
                4'h4:    ret_byte = to_bcd(t_mday);
                4'h5:    ret_byte = to_bcd(t_mon);
                4'h6:    ret_byte = to_bcd(t_yr);
                default: ret_byte = '0;
            endcase
        end else if (cmd_q == CMD_STAT_RD) begin
            is_read  = 1'b1;
            ret_byte = stat_q;
        end else if (cmd_q == CMD_AUX_RD) begin
            is_read  = 1'b1;
            ret_byte = '0;
        end
        ret_bit = ret_byte[3'd7 - eff_cnt];
        drive   = fall && (eff_st == ST_DATA) && is_read;
        ctl_d   = ctl_wdata;
        ctl_d[CTL_DAT] = drive ? ret_bit : dat_w;
    end

    assign ctl_rdata = ctl_q;
    assign irq_ack   = ack_q;

    rtc_nvram #(
        .DEPTH (RAM_DEPTH),
        .WIDTH (8)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (cmd_q[RAM_AW-1:0]),
        .wdata (final_val),
        .raddr (cmd_q[RAM_AW-1:0]),
        .rdata (ram_rdata)
    );

    rtc_timekeeper #(
        .YEAR_SPAN (YEAR_SPAN)
    ) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .sec   (t_sec),
        .min   (t_min),
        .hour  (t_hour),
        .mday  (t_mday),
        .mon   (t_mon),
        .yr    (t_yr)
    );

    // R2
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[CTL_EN]) |=>
            (st_q == ST_IDLE && cmd_q == 8'h00 && val_q == 8'h00));

    // R3
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> ($stable(st_q) && $stable(cnt_q) && $stable(ctl_q)));

    // R9
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !(ctl_we && !ctl_wdata[CTL_EN])) |=>
            (st_q == ST_DONE));

    // R4
    ram_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (st_q == ST_DONE));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R8
    status_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_q) |-> irq_ack);

endmodule

// File: tb/rtc_serial_slave_tb.sv
module rtc_serial_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       sec_tick = 1'b0;
    logic [7:0] ctl_rdata;
    logic       irq_ack;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int ack_cnt  = 0;
    bit done     = 0;

    logic [7:0] ram_m [32];
    logic [7:0] stat_m = 8'h90;
    int         tsec = 0;

    always #5 clk = ~clk;

    rtc_serial_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .sec_tick  (sec_tick),
        .ctl_rdata (ctl_rdata),
        .irq_ack   (irq_ack)
    );

    always @(negedge clk) if (rst_n && irq_ack) ack_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 200000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic bit is_rd(input logic [7:0] c);
        return (c <= 8'h2F) || (c == 8'h30) || (c == 8'h31);
    endfunction

    function automatic logic [7:0] exp_ret(input logic [7:0] c);
        if (c <= 8'h1F) return ram_m[c[4:0]];
        if (c == 8'h30) return stat_m;
        if (c == 8'h20) return 8'(bcd(tsec % 60));
        if (c == 8'h21) return 8'(bcd((tsec / 60) % 60));
        if (c == 8'h22) return 8'(bcd((tsec / 3600) % 24));
        if (c == 8'h24) return 8'(bcd(1 + tsec / 86400));
        if (c == 8'h25) return 8'h01;
        return 8'h00;
    endfunction

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = b;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
        tsec += n;
    endtask

    // nedges falling edges of a transfer, then extra edges with data 1,
    // then enable is dropped. Returns the bits read back in data phases.
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] val,
                        input int nedges, input int extra, input bit noisy,
                        output logic [7:0] ret);
        logic [15:0] bits;
        bits = {cmd, val};
        ret  = '0;
        wr(8'h03);
        for (int p = 0; p < nedges; p++) begin
            logic b;
            b = bits[15 - p];
            wr({5'b0, b, 2'b11});
            if (noisy) wr({5'b0, ~b, 2'b11});
            wr({5'b0, b, 2'b01});
            if (p >= 8) begin
                ret[15 - p] = ctl_rdata[2];
                if (!is_rd(cmd)) chk("R11 pass-through", int'(ctl_rdata[2]), int'(b));
            end
            chk("R11 other bits", int'(ctl_rdata & 8'hFB), 1);
            if (noisy) wr({5'b0, ~b, 2'b01});
        end
        for (int e = 0; e < extra; e++) begin
            wr(8'h07);
            wr(8'h05);
            chk("R9 passthrough after done", int'(ctl_rdata[2]), 1);
        end
        wr(8'h00);
        if (nedges == 16) begin
            if (cmd >= 8'h80 && cmd <= 8'h9F) ram_m[cmd[4:0]] = val;
            if (cmd == 8'hB1 && val[2]) stat_m = stat_m & ~8'h18;
        end
    endtask

    logic [7:0] r;
    int         a0;

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) ram_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl_rdata", int'(ctl_rdata), 8'h00);
        chk("R1 irq_ack", int'(irq_ack), 0);
        xfer(8'h07, 8'h00, 16, 0, 0, r);
        chk("R1 ram reset", int'(r), 8'h00);

        // R6 status and aux
        xfer(8'h30, 8'h00, 16, 0, 0, r);
        chk("R6 status read", int'(r), 8'h90);
        xfer(8'h31, 8'hFF, 16, 0, 0, r);
        chk("R6 aux read", int'(r), 8'h00);

        // R7 time at zero
        xfer(8'h20, 8'h00, 16, 0, 0, r); chk("R7 sec", int'(r), 8'h00);
        xfer(8'h24, 8'h00, 16, 0, 0, r); chk("R7 mday", int'(r), 8'h01);
        xfer(8'h25, 8'h00, 16, 0, 0, r); chk("R7 month", int'(r), 8'h01);
        xfer(8'h26, 8'h00, 16, 0, 0, r); chk("R7 year", int'(r), 8'h00);
        xfer(8'h23, 8'h00, 16, 0, 0, r); chk("R7 unused code", int'(r), 8'h00);

        // R4 / R5 write then read, ends of range
        xfer(8'h80, 8'hA5, 16, 0, 0, r);
        xfer(8'h9F, 8'h3C, 16, 0, 0, r);
        xfer(8'h00, 8'h00, 16, 0, 0, r); chk("R5 read byte 0", int'(r), 8'hA5);
        xfer(8'h1F, 8'h00, 16, 0, 0, r); chk("R4 read byte 31", int'(r), 8'h3C);

        // R3 redundant writes with clock low and toggled data
        xfer(8'h8A, 8'h69, 16, 0, 1, r);
        xfer(8'h0A, 8'h00, 16, 0, 1, r); chk("R3 noisy write/read", int'(r), 8'h69);

        // R2 edges with enable low, then partial transfer aborted
        wr(8'h02); wr(8'h00); wr(8'h06); wr(8'h04); wr(8'h02); wr(8'h00);
        xfer(8'h00, 8'h00, 16, 0, 0, r); chk("R2 enable low ignored", int'(r), 8'hA5);
        xfer(8'h85, 8'hEE, 12, 0, 0, r);
        xfer(8'h05, 8'h00, 16, 0, 0, r); chk("R2 aborted write", int'(r), 8'h00);

        // R9 extra edges after completion
        xfer(8'h81, 8'h5A, 16, 8, 0, r);
        xfer(8'h01, 8'h00, 16, 0, 0, r); chk("R9 value kept", int'(r), 8'h5A);

        // R8 status clear
        xfer(8'hB1, 8'hFB, 16, 0, 0, r);
        chk("R8 no ack without bit2", ack_cnt, 0);
        xfer(8'h30, 8'h00, 16, 0, 0, r); chk("R8 status unchanged", int'(r), 8'h90);
        xfer(8'hB1, 8'h04, 16, 0, 0, r);
        chk("R8 single ack", ack_cnt, 1);
        xfer(8'h30, 8'h00, 16, 0, 0, r); chk("R8 status cleared", int'(r), 8'h80);

        // random mix R4 R5 R6 R7
        for (int k = 0; k < 40; k++) begin
            logic [7:0] c;
            logic [7:0] v;
            a0 = $urandom % 5;
            v  = 8'($urandom);
            case (a0)
                0: c = 8'h80 | 8'($urandom % 32);
                1: c = 8'($urandom % 32);
                2: c = 8'h30;
                3: c = 8'h20 | 8'($urandom % 16);
                default: c = 8'h31;
            endcase
            xfer(c, v, 16, 0, 0, r);
            if (is_rd(c)) chk("R5 R6 R7 random read", int'(r), int'(exp_ret(c)));
        end
        for (int i = 0; i < 32; i++) begin
            xfer(8'(i), 8'h00, 16, 0, 0, r);
            chk("R4 random ram sweep", int'(r), int'(ram_m[i]));
        end

        // R10 R7 time rollover
        ticks(3725);
        xfer(8'h20, 8'h00, 16, 0, 0, r); chk("R10 sec", int'(r), 8'h05);
        xfer(8'h21, 8'h00, 16, 0, 0, r); chk("R10 min", int'(r), 8'h02);
        xfer(8'h22, 8'h00, 16, 0, 0, r); chk("R10 hour", int'(r), 8'h01);
        ticks(90061 - 3725);
        xfer(8'h20, 8'h00, 16, 0, 0, r); chk("R10 sec day2", int'(r), 8'h01);
        xfer(8'h21, 8'h00, 16, 0, 0, r); chk("R10 min day2", int'(r), 8'h01);
        xfer(8'h22, 8'h00, 16, 0, 0, r); chk("R10 hour wrap", int'(r), 8'h01);
        xfer(8'h24, 8'h00, 16, 0, 0, r); chk("R10 day advance", int'(r), 8'h02);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule